// File: doc/BRIEF.md
# Isochronous Host Transmit Endpoint Controller

This block controls one host-side transmit endpoint that carries isochronous OUT traffic. Software sets up the endpoint through a small configuration port: maximum packet size, transaction interval, a FIFO sizing word that selects single or double packet buffering, and a transfer-type word with speed, protocol and target endpoint number. It then announces each packet it loads into the FIFO by writing the control word with its packet-ready bit set. The block counts those packets and waits for the interval slot, which it derives from a frame/microframe tick. When the slot comes and a packet is waiting, it asks the downstream packet engine to send an OUT token and the oldest packet. The request stays up until the engine acknowledges.

A DMA request line stays high while DMA is enabled and the packet queue has a free slot, so a DMA controller can top up the FIFO. Interrupts are single-cycle pulses. Without DMA, every completed packet raises one. With DMA, only errors raise one. The only error here is an underrun: an interval slot that finds no packet queued.

Top module: `iso_tx_ep_ctrl`

## Requirements
- R1: After reset, `csr_rdata` reads 0, and `eng_req`, `dma_req` and `ep_irq` are low.
- R2: A control write with bit 0 set queues one packet. Control read bit 0 reads 1 while any queued packet is unsent and returns to 0 once the queue is empty.
- R3: The queue holds one packet, or two when bit 4 of the FIFO sizing word (`cfg_sel`=2) is set. A packet-ready write to a full queue is ignored unless a packet completes in that same cycle.
- R4: Interval slots fall on every N-th `frame_tick`, where N is the interval word (`cfg_sel`=1) and 0 counts as 1. Writing the interval restarts the count. When a slot finds a packet queued and no send in progress, `eng_req` rises after that tick's clock edge and stays high until `eng_ack`. While it is high, `eng_len` carries the size word (`cfg_sel`=0), `eng_speed` carries type bits 7:6 and `eng_ep` carries type bits 3:0 (`cfg_sel`=3).
- R5: Slots act only when control bit 13 (FIFO mode) is set and type bits 5:4 equal binary 01. Otherwise a slot neither starts a send nor flags an underrun.
- R6: `dma_req` is high exactly when control bit 12 (DMA enable) is set and the queue has room.
- R7: With DMA disabled, `ep_irq` pulses for one cycle right after the edge that takes `eng_ack` during a send, provided `int_en` is high.
- R8: With DMA enabled, a packet completion produces no `ep_irq`.
- R9: An active slot with an empty queue and no send in progress sets control read bit 2 and pulses `ep_irq` when `int_en` is high, whether or not DMA is enabled. Any control write with bit 2 clear clears that bit.
- R10: Control bits 13, 12 and 10 read back as written. Bit 11 (force toggle) is ignored and reads 0.
- R11: A packet-ready write in the same cycle as a completion leaves the queue count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 size, 1 interval, 2 FIFO sizing, 3 transfer type |
| cfg_wdata | input | 16 | Configuration write data |
| int_en | input | 1 | Endpoint interrupt enable |
| frame_tick | input | 1 | One-cycle frame/microframe start pulse |
| eng_ack | input | 1 | Packet engine finished the current packet |
| csr_rdata | output | 16 | Control word read value |
| eng_req | output | 1 | Request to send OUT token plus packet |
| eng_len | output | 11 | Maximum packet size for the engine |
| eng_ep | output | 4 | Target endpoint number |
| eng_speed | output | 2 | Operating speed code |
| dma_req | output | 1 | Queue has room for another packet (DMA mode) |
| ep_irq | output | 1 | Endpoint interrupt pulse |

## Verification
Two pairs of events can land in the same clock edge.

The first pair is a software packet-ready write and the engine's completion acknowledge. The bench fills a single-buffer queue, starts a send, and then drives the write and `eng_ack` together. It then checks that the packet-ready bit stays set, that the completion interrupt still fires, and that the next slot sends the queued packet.

The second pair is the completion and the interrupt gating. The bench sweeps buffering depth against DMA enable, so every drain checks the interrupt against the DMA setting and every fill checks the DMA request against the remaining room.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  localparam int CSR_PKTRDY  = 0;
  localparam int CSR_URUN    = 2;
  localparam int CSR_DMAMODE = 10;
  localparam int CSR_FRCTOG  = 11;
  localparam int CSR_DMAEN   = 12;
  localparam int CSR_MODE    = 13;
  localparam int FSZ_DBL     = 4;
  localparam logic [1:0] PROTO_ISO = 2'b01;

  typedef enum logic [1:0] {
    CFG_SIZE = 2'd0,
    CFG_IVAL = 2'd1,
    CFG_FSZ  = 2'd2,
    CFG_TYPE = 2'd3
  } cfg_sel_e;

  // slot is due when the next tick completes the interval (0 acts as 1)
  function automatic logic slot_due(input logic [15:0] cnt, input logic [15:0] ival);
    logic [16:0] eff;
    eff = (ival == 16'd0) ? 17'd1 : {1'b0, ival};
    return ({1'b0, cnt} + 17'd1) >= eff;
  endfunction

  // interrupt cause combination
  function automatic logic irq_fire(input logic en, input logic dma, input logic done,
                                    input logic urun);
    return en & ((done & ~dma) | urun);
  endfunction
endpackage

// File: rtl/iso_tx_slot_timer.sv
module iso_tx_slot_timer #(
  parameter int IVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ival_wr,
  input  logic [IVAL_W-1:0] ival_wdata,
  input  logic              frame_tick,
  output logic              slot
);
  import iso_tx_pkg::*;

  logic [IVAL_W-1:0] ival;
  logic [IVAL_W-1:0] cnt;

  assign slot = frame_tick & slot_due(16'(cnt), 16'(ival));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival <= '0;
      cnt  <= '0;
    end else if (ival_wr) begin
      ival <= ival_wdata;
      cnt  <= '0;
    end else if (frame_tick) begin
      cnt <= slot ? '0 : cnt + 1'b1;
    end
  end

  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    slot && !ival_wr |=> cnt == '0); // R4
endmodule

// File: rtl/iso_tx_pkt_queue.sv
module iso_tx_pkt_queue #(
  parameter int MAX_PKTS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dbl,
  input  logic                          push_req,
  input  logic                          pop,
  output logic [$clog2(MAX_PKTS+1)-1:0] count,
  output logic                          room
);
  localparam int CW = $clog2(MAX_PKTS + 1);
  localparam logic [CW-1:0] CAP_DBL = CW'(MAX_PKTS);
  localparam logic [CW-1:0] CAP_ONE = CW'(1);

  logic [CW-1:0] cap;
  logic          push_ok;

  assign cap     = dbl ? CAP_DBL : CAP_ONE;
  assign room    = count < cap;
  assign push_ok = push_req & (room | pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (push_ok && !pop)  count <= count + 1'b1;
    else if (!push_ok && pop)  count <= count - 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !room && !pop |=> count == $past(count)); // R3
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && pop |=> count == $past(count)); // R11
endmodule

// File: rtl/iso_tx_ep_ctrl.sv
module iso_tx_ep_ctrl #(
  parameter int MPS_W    = 11,
  parameter int IVAL_W   = 8,
  parameter int MAX_PKTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [15:0]      csr_wdata,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [15:0]      cfg_wdata,
  input  logic             int_en,
  input  logic             frame_tick,
  input  logic             eng_ack,
  output logic [15:0]      csr_rdata,
  output logic             eng_req,
  output logic [MPS_W-1:0] eng_len,
  output logic [3:0]       eng_ep,
  output logic [1:0]       eng_speed,
  output logic             dma_req,
  output logic             ep_irq
);
  import iso_tx_pkg::*;

  localparam int CW = $clog2(MAX_PKTS + 1);

  logic [MPS_W-1:0] maxp;
  logic [7:0]       ttype;
  logic             dbl, mode, dmaen, dmamode, urun_flag, busy, irq_q;
  logic [CW-1:0]    count;
  logic             room, slot, enabled, start, urun_evt, pop, push_req, ival_wr;
  logic             unused_bits;

  assign unused_bits = ^{csr_wdata[15:14], csr_wdata[CSR_FRCTOG], csr_wdata[9:3],
                         csr_wdata[1], cfg_wdata[15:8]};

  assign ival_wr  = cfg_wr && (cfg_sel == CFG_IVAL);
  assign push_req = csr_wr & csr_wdata[CSR_PKTRDY];
  assign pop      = eng_ack & busy;
  assign enabled  = mode & (ttype[5:4] == PROTO_ISO);
  assign start    = slot & enabled & (count != '0) & ~busy;
  assign urun_evt = slot & enabled & (count == '0) & ~busy;

  iso_tx_slot_timer #(.IVAL_W(IVAL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ival_wr(ival_wr),
    .ival_wdata(cfg_wdata[IVAL_W-1:0]), .frame_tick(frame_tick), .slot(slot)
  );

  iso_tx_pkt_queue #(.MAX_PKTS(MAX_PKTS)) u_queue (
    .clk(clk), .rst_n(rst_n), .dbl(dbl), .push_req(push_req), .pop(pop),
    .count(count), .room(room)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maxp  <= '0;
      ttype <= '0;
      dbl   <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        CFG_SIZE: maxp  <= cfg_wdata[MPS_W-1:0];
        CFG_FSZ:  dbl   <= cfg_wdata[FSZ_DBL];
        CFG_TYPE: ttype <= cfg_wdata[7:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= 1'b0;
      dmaen     <= 1'b0;
      dmamode   <= 1'b0;
      urun_flag <= 1'b0;
    end else begin
      if (csr_wr) begin
        mode    <= csr_wdata[CSR_MODE];
        dmaen   <= csr_wdata[CSR_DMAEN];
        dmamode <= csr_wdata[CSR_DMAMODE];
      end
      if (urun_evt)                              urun_flag <= 1'b1;
      else if (csr_wr && !csr_wdata[CSR_URUN])   urun_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (start)    busy <= 1'b1;
      else if (pop) busy <= 1'b0;
      irq_q <= irq_fire(int_en, dmaen, pop, urun_evt);
    end
  end

  always_comb begin
    csr_rdata              = '0;
    csr_rdata[CSR_PKTRDY]  = (count != '0);
    csr_rdata[CSR_URUN]    = urun_flag;
    csr_rdata[CSR_DMAMODE] = dmamode;
    csr_rdata[CSR_DMAEN]   = dmaen;
    csr_rdata[CSR_MODE]    = mode;
  end

  assign eng_req   = busy;
  assign eng_len   = maxp;
  assign eng_ep    = ttype[3:0];
  assign eng_speed = ttype[7:6];
  assign dma_req   = dmaen & room;
  assign ep_irq    = irq_q;

  AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> eng_req); // R4
  AST_DMA_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    dmaen && count == '0 |-> dma_req); // R6
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !dmaen && int_en |=> ep_irq); // R7
  AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pop && dmaen |=> !ep_irq); // R8
  AST_URUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    urun_evt |=> csr_rdata[CSR_URUN]); // R9
endmodule

// File: tb/iso_tx_ep_ctrl_test.sv
module iso_tx_ep_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        int_en = 1'b0;
  logic        frame_tick = 1'b0;
  logic        eng_ack = 1'b0;
  logic [15:0] csr_rdata;
  logic        eng_req, dma_req, ep_irq;
  logic [10:0] eng_len;
  logic [3:0]  eng_ep;
  logic [1:0]  eng_speed;

  int checks = 0;
  int fails = 0;
  logic [15:0] base;

  always #5 clk = ~clk;

  iso_tx_ep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .int_en(int_en),
    .frame_tick(frame_tick), .eng_ack(eng_ack), .csr_rdata(csr_rdata),
    .eng_req(eng_req), .eng_len(eng_len), .eng_ep(eng_ep), .eng_speed(eng_speed),
    .dma_req(dma_req), .ep_irq(ep_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [15:0] v);
    @(negedge clk); csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic wr_cfg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); eng_ack = 1'b1;
    @(negedge clk); eng_ack = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 csr_rdata", csr_rdata, 0);
    chk("R1 eng_req", eng_req, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 ep_irq", ep_irq, 0);

    wr_cfg(2'd0, 16'd188);
    wr_cfg(2'd3, 16'h0095);   // speed 2, iso, endpoint 5
    wr_cfg(2'd1, 16'd1);
    int_en = 1'b1;
    base = 16'h2000;
    wr_csr(16'h2C00);          // mode, dma-mode, force toggle
    chk("R10 readback", csr_rdata, 16'h2400);
    wr_csr(base);
    chk("R10 clear dma-mode", csr_rdata, 16'h2000);

    wr_csr(base | 16'h1);
    chk("R2 pktrdy set", csr_rdata[0], 1);
    wr_csr(base | 16'h1);      // single buffer full: ignored
    tick();
    chk("R4 eng_req after slot", eng_req, 1);
    chk("R4 eng_len", eng_len, 188);
    chk("R4 eng_ep", eng_ep, 5);
    chk("R4 eng_speed", eng_speed, 2);
    @(negedge clk);
    chk("R4 eng_req held", eng_req, 1);
    ack();
    chk("R7 irq on completion", ep_irq, 1);
    chk("R4 eng_req drop", eng_req, 0);
    chk("R3 extra push dropped", csr_rdata[0], 0);
    @(negedge clk);
    chk("R7 irq one cycle", ep_irq, 0);

    tick();
    chk("R9 underrun flag", csr_rdata[2], 1);
    chk("R9 underrun irq", ep_irq, 1);
    chk("R9 no send", eng_req, 0);
    wr_csr(base);
    chk("R9 flag cleared", csr_rdata[2], 0);

    // interval sweep
    for (int iv = 0; iv < 5; iv++) begin
      int eff;
      eff = (iv == 0) ? 1 : iv;
      wr_cfg(2'd1, 16'(iv));
      wr_csr(base | 16'h1);
      for (int t = 1; t <= eff; t++) begin
        tick();
        chk($sformatf("R4 interval %0d tick %0d", iv, t), eng_req, (t == eff) ? 1 : 0);
      end
      ack();
    end
    wr_cfg(2'd1, 16'd1);

    // buffering depth x DMA sweep
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 2; m++) begin
        int cap;
        cap = d ? 2 : 1;
        base = 16'h2000 | (m ? 16'h1400 : 16'h0);
        wr_cfg(2'd2, d ? 16'h0010 : 16'h0);
        wr_csr(base);
        for (int k = 0; k < 3; k++) begin
          int e;
          e = (k < cap) ? k : cap;
          chk($sformatf("R6 dma d%0d m%0d k%0d", d, m, k), dma_req, (m && e < cap) ? 1 : 0);
          chk($sformatf("R2 pktrdy d%0d m%0d k%0d", d, m, k), csr_rdata[0], (e > 0) ? 1 : 0);
          wr_csr(base | 16'h1);
        end
        chk($sformatf("R3 full d%0d m%0d", d, m), dma_req, 0);
        for (int j = 0; j < cap; j++) begin
          tick();
          chk($sformatf("R4 send d%0d m%0d j%0d", d, m, j), eng_req, 1);
          ack();
          chk($sformatf("R7 R8 irq d%0d m%0d j%0d", d, m, j), ep_irq, m ? 0 : 1);
          chk($sformatf("R2 pktrdy drain d%0d m%0d j%0d", d, m, j), csr_rdata[0],
              (cap - j - 1 > 0) ? 1 : 0);
          chk($sformatf("R6 dma drain d%0d m%0d j%0d", d, m, j), dma_req, m);
        end
        tick();
        chk($sformatf("R9 underrun irq d%0d m%0d", d, m), ep_irq, 1);
        wr_csr(base);
      end
    end
    base = 16'h2000;
    wr_cfg(2'd2, 16'h0);
    wr_csr(base);

    // R5: mode off, then wrong protocol
    wr_csr(16'h0001);
    tick();
    chk("R5 mode off no send", eng_req, 0);
    chk("R5 mode off no underrun", csr_rdata[2], 0);
    wr_cfg(2'd3, 16'h00A5);
    wr_csr(base);
    tick();
    chk("R5 bad protocol no send", eng_req, 0);
    chk("R5 bad protocol irq", ep_irq, 0);
    wr_cfg(2'd3, 16'h0095);
    tick();
    chk("R5 enabled send", eng_req, 1);

    // R11: push and completion in the same edge, single buffer
    @(negedge clk); csr_wr = 1'b1; csr_wdata = base | 16'h1; eng_ack = 1'b1;
    @(negedge clk); csr_wr = 1'b0; eng_ack = 1'b0;
    chk("R11 pktrdy kept", csr_rdata[0], 1);
    chk("R11 completion irq", ep_irq, 1);
    chk("R11 engine idle", eng_req, 0);
    tick();
    chk("R11 next send", eng_req, 1);
    int_en = 1'b0;
    ack();
    chk("R7 irq gated", ep_irq, 0);
    chk("R11 queue empty", csr_rdata[0], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule